// File: doc/BRIEF.md
# Ring-Oscillator PUF Response Generator

This block turns a row of free-running ring-oscillator signals into a binary fingerprint of the device. After a start pulse it clears one edge counter per oscillator. It then counts the rising edges of every oscillator for a fixed number of system clocks. When that window closes it compares each oscillator with its next neighbour, one pair per clock.

Each comparison gives a signed-difference word. The sign of that word forms the first-order response, with one bit per pair. Next to each sign bit the block also keeps one selected bit of the difference magnitude. This gives a second-order response of twice the length. The oscillator inputs are asynchronous to the system clock and are brought into its domain by synchronisers. During simulation, any toggling signal can stand in for an oscillator.

A host pulses `start`, waits for the one-cycle `done`, and then reads both response vectors. It can also read the full difference word of any pair through an index-addressed readout port.

Top module: `ropuf_resp_gen`

## Requirements
- R1: A `start` pulse seen while idle raises `busy` on the next cycle. `done` is high for exactly one cycle, WINDOW + NUM_OSC − 1 clock edges after the edge that sampled `start`. At that point `busy` is low again.
- R2: During the window, each oscillator's counter counts the rising edges of that oscillator. Edges that arrive while the block is idle leave the counts unchanged.
- R3: `rdWord` for pair p (`rdIdx` = p) has the sign in bit 31 and the magnitude in bits 30..0. The sign is 1 when count[p] < count[p+1]. The magnitude is |count[p] − count[p+1]|.
- R4: When two counts are equal, the sign bit is 0 and the magnitude is 0.
- R5: Bit p of `respFirst` holds the sign of pair p, so pair 0 sits at the LSB.
- R6: Bit 2p of `respSecond` holds the sign of pair p. Bit 2p+1 holds bit EXTRA_BIT (default 0) of that pair's magnitude.
- R7: Both response vectors clear to zero on an accepted `start`. After `done` they keep their values until the next accepted `start`.
- R8: A `start` pulse that arrives while `busy` is high is ignored. It changes neither the timing of `done` nor the results.
- R9: After reset, `busy`, `done`, both response vectors and `rdWord` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a measurement (used only when idle) |
| oscIn | input | NUM_OSC | Ring-oscillator outputs, asynchronous |
| rdIdx | input | $clog2(NUM_OSC-1) | Pair selected for readout |
| busy | output | 1 | Measurement or comparison in progress |
| done | output | 1 | One-cycle pulse after the last pair is stored |
| rdWord | output | CNT_W+1 | Sign and magnitude of the selected pair |
| respFirst | output | NUM_OSC-1 | Sign bits, one per pair |
| respSecond | output | 2*(NUM_OSC-1) | Sign and extra bit, interleaved per pair |

## Verification
`busy` is due one cycle after the sampling edge of `start`. `done` is due exactly WINDOW + 50 edges after that edge. The bench records the cycle of the sampling edge and checks the measured latency against that figure. The bench drives oscillator pulses at the falling clock edge, two cycles high and two cycles low, and keeps them inside the window with margin for the three-flop synchroniser delay. Because of this, the expected counts are exact. Responses are compared on the cycle in which `done` is seen, again one cycle later, and after idle-time pulses that must not disturb them.

// File: rtl/ropuf_pkg.sv
package ropuf_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrAll;   // clear counters and responses
    logic measEn;   // counting window open
    logic procEn;   // compare the pair at pairIdx
  } ctrlStrobe_t;

endpackage

// File: rtl/ropuf_ctrl.sv
module ropuf_ctrl
  import ropuf_pkg::*;
#(
  parameter int NUM_PAIR = 50,
  parameter int WINDOW   = 256
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  output ctrlStrobe_t                 strb,
  output logic [$clog2(NUM_PAIR)-1:0] pairIdx,
  output logic                        busy,
  output logic                        done
);

  localparam int IDX_W = $clog2(NUM_PAIR);
  localparam int WIN_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_MEAS, ST_PROC} state_t;

  state_t             state;
  logic [WIN_W-1:0]   winCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      winCnt  <= '0;
      pairIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_MEAS;
            winCnt <= '0;
          end
        end
        ST_MEAS: begin
          if (winCnt == WIN_W'(WINDOW - 1)) begin
            state   <= ST_PROC;
            pairIdx <= '0;
          end else begin
            winCnt <= winCnt + 1'b1;
          end
        end
        ST_PROC: begin
          if (pairIdx == IDX_W'(NUM_PAIR - 1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            pairIdx <= pairIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.clrAll = (state == ST_IDLE) && start;
    strb.measEn = (state == ST_MEAS);
    strb.procEn = (state == ST_PROC);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ropuf_datapath.sv
module ropuf_datapath
  import ropuf_pkg::*;
#(
  parameter int NUM_OSC   = 51,
  parameter int CNT_W     = 31,
  parameter int EXTRA_BIT = 0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobe_t                    strb,
  input  logic [$clog2(NUM_OSC-1)-1:0]   pairIdx,
  input  logic [NUM_OSC-1:0]             oscIn,
  input  logic [$clog2(NUM_OSC-1)-1:0]   rdIdx,
  output logic [CNT_W:0]                 rdWord,
  output logic [NUM_OSC-2:0]             respFirst,
  output logic [2*(NUM_OSC-1)-1:0]       respSecond
);

  localparam int NUM_PAIR = NUM_OSC - 1;
  localparam int IDX_W    = $clog2(NUM_PAIR);

  logic [CNT_W-1:0] cnt [NUM_OSC];

  // Synchroniser, edge detector and counter for each oscillator
  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    logic [2:0] syncSh;
    logic       riseSeen;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncSh <= '0;
      else       syncSh <= {syncSh[1:0], oscIn[g]};
    end

    assign riseSeen = syncSh[1] & ~syncSh[2];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         cnt[g] <= '0;
      else if (strb.clrAll)              cnt[g] <= '0;
      else if (strb.measEn && riseSeen)  cnt[g] <= cnt[g] + 1'b1;
    end
  end

  function automatic logic [CNT_W:0] pairWord(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
    logic             neg;
    logic [CNT_W-1:0] mag;
    neg = (a < b);
    mag = neg ? (b - a) : (a - b);
    return {neg, mag};
  endfunction

  logic [CNT_W:0] procWord;
  logic [IDX_W-1:0] rdSafe;
  logic             rdValid;

  assign procWord = pairWord(cnt[pairIdx], cnt[pairIdx + 1'b1]);

  assign rdValid = (int'(rdIdx) < NUM_PAIR);
  assign rdSafe  = rdValid ? rdIdx : '0;
  assign rdWord  = rdValid ? pairWord(cnt[rdSafe], cnt[rdSafe + 1'b1]) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respFirst  <= '0;
      respSecond <= '0;
    end else if (strb.clrAll) begin
      respFirst  <= '0;
      respSecond <= '0;
    end else if (strb.procEn) begin
      respFirst[pairIdx]            <= procWord[CNT_W];
      respSecond[{pairIdx, 1'b0}]   <= procWord[CNT_W];
      respSecond[{pairIdx, 1'b1}]   <= procWord[EXTRA_BIT];
    end
  end

endmodule

// File: rtl/ropuf_resp_gen.sv
module ropuf_resp_gen
  import ropuf_pkg::*;
#(
  parameter int NUM_OSC   = 51,
  parameter int CNT_W     = 31,
  parameter int WINDOW    = 256,
  parameter int EXTRA_BIT = 0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [NUM_OSC-1:0]           oscIn,
  input  logic [$clog2(NUM_OSC-1)-1:0] rdIdx,
  output logic                         busy,
  output logic                         done,
  output logic [CNT_W:0]               rdWord,
  output logic [NUM_OSC-2:0]           respFirst,
  output logic [2*(NUM_OSC-1)-1:0]     respSecond
);

  localparam int NUM_PAIR = NUM_OSC - 1;

  ctrlStrobe_t                 strb;
  logic [$clog2(NUM_PAIR)-1:0] pairIdx;

  ropuf_ctrl #(.NUM_PAIR(NUM_PAIR), .WINDOW(WINDOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strb(strb), .pairIdx(pairIdx), .busy(busy), .done(done)
  );

  ropuf_datapath #(.NUM_OSC(NUM_OSC), .CNT_W(CNT_W), .EXTRA_BIT(EXTRA_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pairIdx(pairIdx),
    .oscIn(oscIn), .rdIdx(rdIdx), .rdWord(rdWord),
    .respFirst(respFirst), .respSecond(respSecond)
  );

endmodule

// File: rtl/ropuf_resp_gen_chk.sv
module ropuf_resp_gen_chk #(
  parameter int NUM_OSC = 51
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       start,
  input logic                       busy,
  input logic                       done,
  input logic [NUM_OSC-2:0]         respFirst,
  input logic [2*(NUM_OSC-1)-1:0]   respSecond
);

  logic [NUM_OSC-2:0] evenBits;

  always_comb begin
    for (int i = 0; i < NUM_OSC - 1; i++) evenBits[i] = respSecond[2*i];
  end

  // R1: done lasts one cycle
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1: done comes with return to idle
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R1: busy only rises after a start
  p_busy_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R6: sign bits agree between both responses when finished
  p_sign_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (respFirst == evenBits));

  // R7: accepted start clears responses
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && respFirst == '0 && respSecond == '0));

  // R7: responses hold while idle
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(respFirst) && $stable(respSecond)));

endmodule

bind ropuf_resp_gen ropuf_resp_gen_chk #(.NUM_OSC(NUM_OSC)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .respFirst(respFirst), .respSecond(respSecond)
);

// File: tb/ropuf_resp_gen_test.sv
`timescale 1ns/1ps
module ropuf_resp_gen_test;

  localparam int NOSC = 51;
  localparam int NP   = NOSC - 1;
  localparam int CW   = 31;
  localparam int WIN  = 256;
  localparam int XB   = 0;
  localparam int IW   = $clog2(NP);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic [NOSC-1:0] oscIn = '0;
  logic [IW-1:0]   rdIdx = '0;
  logic            busy, done;
  logic [CW:0]     rdWord;
  logic [NP-1:0]   respFirst;
  logic [2*NP-1:0] respSecond;

  always #2.5 clk = ~clk;

  ropuf_resp_gen #(.NUM_OSC(NOSC), .CNT_W(CW), .WINDOW(WIN), .EXTRA_BIT(XB)) uut (
    .clk(clk), .rstN(rstN), .start(start), .oscIn(oscIn), .rdIdx(rdIdx),
    .busy(busy), .done(done), .rdWord(rdWord),
    .respFirst(respFirst), .respSecond(respSecond)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycleCnt = 0;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  typedef struct {
    logic [NP-1:0]   r1;
    logic [2*NP-1:0] r2;
    int              startCyc;
  } expItem_t;

  expItem_t expQ[$];
  int k [NOSC];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [CW:0] expWord(input int p);
    int d;
    logic neg;
    d = k[p] - k[p+1];
    neg = (d < 0);
    if (neg) d = -d;
    return {neg, CW'(d)};
  endfunction

  // Monitor: pops the expected item on each done
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R1", "done without a start", 1, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          chk(cycleCnt - it.startCyc == WIN + NP, "R1", "done latency",
              cycleCnt - it.startCyc, WIN + NP);
          chk(!busy, "R1", "busy at done", busy, 0);
          chk(respFirst == it.r1, "R5", "first-order response", respFirst, it.r1);
          chk(respSecond == it.r2, "R6", "second-order response", respSecond, it.r2);
          @(negedge clk);
          chk(!done, "R1", "done width", done, 0);
          chk(respFirst == it.r1 && respSecond == it.r2, "R7", "hold after done",
              respFirst, it.r1);
        end
      end
    end
  end

  // Driver: pushes expectations, runs one measurement, sweeps readout
  task automatic runMeas(input bit midStart);
    expItem_t it;
    int maxK = 0;
    logic [NP-1:0] r1Snap;
    for (int p = 0; p < NP; p++) begin
      logic [CW:0] w;
      w = expWord(p);
      it.r1[p]       = w[CW];
      it.r2[2*p]     = w[CW];
      it.r2[2*p+1]   = w[XB];
    end
    for (int i = 0; i < NOSC; i++) if (k[i] > maxK) maxK = k[i];
    @(negedge clk);
    start = 1'b1;
    it.startCyc = cycleCnt + 1;
    expQ.push_back(it);
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R1", "busy after start", busy, 1);
    chk(respFirst == '0 && respSecond == '0, "R7", "clear on start", respFirst, 0);
    repeat (3) @(negedge clk);
    for (int c = 0; c <= 4 * maxK; c++) begin
      for (int i = 0; i < NOSC; i++) oscIn[i] = ((c % 4) < 2) && ((c / 4) < k[i]);
      start = (midStart && (c == 20)); // R8: stray start while busy
      @(negedge clk);
    end
    oscIn = '0;
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      rdIdx = IW'(p);
      #1;
      chk(rdWord == expWord(p), (k[p] == k[p+1]) ? "R4" : "R3",
          $sformatf("readout pair %0d", p), rdWord, expWord(p));
    end
    // R2: idle-time edges must not move the counts
    r1Snap = respFirst;
    for (int c = 0; c < 12; c++) begin
      oscIn = ((c % 4) < 2) ? {NOSC{1'b1}} : '0;
      @(negedge clk);
    end
    oscIn = '0;
    repeat (4) @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      rdIdx = IW'(p);
      #1;
      chk(rdWord == expWord(p), "R2", "counts frozen while idle", rdWord, expWord(p));
    end
    chk(respFirst == r1Snap, "R7", "response held while idle", respFirst, r1Snap);
  endtask

  task automatic mainSeq();
    int s;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R9", "reset flags", {busy, done}, 0);
    chk(respFirst == '0 && respSecond == '0, "R9", "reset responses", respSecond, 0);
    chk(rdWord == '0, "R9", "reset readout", rdWord, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // ramp: every sign 1, magnitude 1
    for (int i = 0; i < NOSC; i++) k[i] = i;
    runMeas(1'b0);
    // all equal: zero difference is positive
    for (int i = 0; i < NOSC; i++) k[i] = 20;
    runMeas(1'b0);
    // pseudo-random counts with a stray start in the window
    s = 7;
    for (int i = 0; i < NOSC; i++) begin
      s = s * 1103515245 + 12345;
      k[i] = ((s >>> 16) & 32'h7fff) % 48 + 1;
    end
    runMeas(1'b1);
    // alternating counts: magnitude 3, odd
    for (int i = 0; i < NOSC; i++) k[i] = (i % 2 == 0) ? 10 : 13;
    runMeas(1'b0);
    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R1", "all runs completed", expQ.size(), 0);
  endtask

  initial begin
    fork
      mainSeq();
      begin
        repeat (150000) @(posedge clk);
        nFails++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule